// File: doc/BRIEF.md
# Hoisted-Load Alias Tracker

This block lets a scheduler move a load above earlier stores whose addresses are not yet known to differ from the load's address. When the hoisted load runs, it records its destination register number, its memory address and a deferred-exception flag in a small associative table. Every store that follows presents its address. Any tracked entry that falls in the same aligned doubleword as the store is then marked as stale.

Later in the program, a check on the destination register asks whether the hoisted value can still be trusted. There are two kinds of check. The load-check kind answers with a refetch request, so the load can simply be reissued. The advance-check kind answers with a fix-up request, for the case where the stale value may already have been consumed. In that case, control has to branch to recovery code. Both kinds also raise any exception that was deferred for the load. The cache access and the recovery code belong to other blocks.

Top module: `loadAliasTable`

## Requirements
- R1: After reset the table holds no entry. `chkResp`, `refetch`, `fixup` and `excRaise` are low, and the first check on any register reports a miss.
- R2: An allocation records the register number, the address and the exception flag. Later load-checks on that register, with no matching store in between, report no refetch. A load-check never changes the table.
- R3: A store marks a valid entry when the two addresses agree in every bit above bit 2. Bits 2..0 are ignored, and a store to another doubleword leaves the entry unmarked.
- R4: A load-check (`chkKind` = 0) on a marked entry gives `refetch` = 1 and `fixup` = 0. `refetch` and `fixup` are never high together.
- R5: An advance-check (`chkKind` = 1) on a marked entry gives `fixup` = 1 and `refetch` = 0. Every advance-check that finds its entry then removes that entry, marked or not, so the next check on that register is a miss.
- R6: A check on a register with no valid entry counts as a conflict. A load-check then gives `refetch` = 1, and an advance-check gives `fixup` = 1.
- R7: A check that finds an entry whose deferred-exception flag is set gives `excRaise` = 1. A miss never raises `excRaise`.
- R8: A new allocation to a register that already has an entry overwrites that entry, including its address and exception flag, and clears its conflict mark.
- R9: When a store and an allocation occur in the same cycle, the newly written entry is left unmarked, even if the addresses match.
- R10: An allocation for a new register takes the lowest-numbered free entry among 16. When all entries are valid, it evicts the entry named by a round-robin pointer. The pointer starts at 0 after reset and steps by one, wrapping, on each such eviction.
- R11: A check issued in one cycle is answered in the next cycle, with `chkResp` high for exactly that cycle. The answer reflects the table as it stood before any allocation, store or removal in the check's own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| allocValid | input | 1 | A hoisted load is allocating an entry |
| allocReg | input | REG_W | Destination register of the hoisted load |
| allocAddr | input | ADDR_W | Address accessed by the hoisted load |
| allocExc | input | 1 | The hoisted load deferred an exception |
| storeValid | input | 1 | A store address is being snooped |
| storeAddr | input | ADDR_W | Store address |
| chkValid | input | 1 | A check request is present |
| chkReg | input | REG_W | Register being checked |
| chkKind | input | 1 | 0 = load-check, 1 = advance-check |
| chkResp | output | 1 | Check answer valid (one cycle after request) |
| refetch | output | 1 | Load-check: reissue the load |
| fixup | output | 1 | Advance-check: branch to recovery code |
| excRaise | output | 1 | Deferred exception must be raised now |

## Verification
The hardest state to reach from the ports is round-robin eviction, which only starts once all sixteen entries hold distinct registers. The free slots that advance-checks leave behind make the victim order depend on the whole history. The stimulus draws registers from a pool of twenty and addresses from a few doublewords with random low bits. This keeps the table full for long stretches while stores, removals and reallocations collide on the same entries. Directed cycles also put a store and an allocation to one doubleword in the same cycle, and place a check beside a store that hits its own entry.

// File: rtl/latPkg.sv
package latPkg;
  localparam int unsigned ENTRIES = 16;
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  typedef enum logic {
    CHK_LOAD = 1'b0,
    CHK_ADV  = 1'b1
  } chkKindT;

  // strobes from control to datapath, one-hot or per-entry vectors
  typedef struct packed {
    logic [ENTRIES-1:0] allocSel;
    logic [ENTRIES-1:0] clearSel;
    logic [ENTRIES-1:0] markSel;
    logic               allocExc;
  } strobeT;
endpackage

// File: rtl/latData.sv
module latData
  import latPkg::*;
#(
  parameter int unsigned REG_W    = 7,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned LINE_LSB = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strobe,
  input  logic [REG_W-1:0]   allocReg,
  input  logic [ADDR_W-1:0]  allocAddr,
  input  logic [ADDR_W-1:0]  storeAddr,
  input  logic [REG_W-1:0]   chkReg,
  output logic [ENTRIES-1:0] allocRegHit,
  output logic [ENTRIES-1:0] chkRegHit,
  output logic [ENTRIES-1:0] storeAddrHit,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] confVec,
  output logic [ENTRIES-1:0] excVec
);
  localparam int unsigned TAG_W = ADDR_W - LINE_LSB;

  typedef struct packed {
    logic             vld;
    logic             conf;
    logic             exc;
    logic [REG_W-1:0] rnum;
    logic [TAG_W-1:0] tag;
  } entT;

  entT ent [ENTRIES];

  logic [TAG_W-1:0] allocTag;
  logic [TAG_W-1:0] storeTag;
  assign allocTag = allocAddr[ADDR_W-1:LINE_LSB];
  assign storeTag = storeAddr[ADDR_W-1:LINE_LSB];

  for (genvar e = 0; e < ENTRIES; e++) begin : gEnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ent[e] <= '0;
      end else if (strobe.allocSel[e]) begin
        ent[e].vld  <= 1'b1;
        ent[e].conf <= 1'b0;
        ent[e].exc  <= strobe.allocExc;
        ent[e].rnum <= allocReg;
        ent[e].tag  <= allocTag;
      end else if (strobe.clearSel[e]) begin
        ent[e].vld  <= 1'b0;
        ent[e].conf <= 1'b0;
        ent[e].exc  <= 1'b0;
      end else if (strobe.markSel[e]) begin
        ent[e].conf <= 1'b1;
      end
    end

    assign allocRegHit[e]  = ent[e].vld && (ent[e].rnum == allocReg);
    assign chkRegHit[e]    = ent[e].vld && (ent[e].rnum == chkReg);
    assign storeAddrHit[e] = ent[e].vld && (ent[e].tag == storeTag);
    assign validVec[e]     = ent[e].vld;
    assign confVec[e]      = ent[e].conf;
    assign excVec[e]       = ent[e].exc;
  end
endmodule

// File: rtl/latCtrl.sv
module latCtrl
  import latPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               allocValid,
  input  logic               allocExc,
  input  logic               storeValid,
  input  logic               chkValid,
  input  logic               chkKind,
  input  logic [ENTRIES-1:0] allocRegHit,
  input  logic [ENTRIES-1:0] chkRegHit,
  input  logic [ENTRIES-1:0] storeAddrHit,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] confVec,
  input  logic [ENTRIES-1:0] excVec,
  output strobeT             strobe,
  output logic               chkResp,
  output logic               refetch,
  output logic               fixup,
  output logic               excRaise
);
  localparam logic [ENTRIES-1:0] ONE = {{(ENTRIES-1){1'b0}}, 1'b1};

  logic [IDX_W-1:0]   rrPtr;
  logic [ENTRIES-1:0] freeVec, freeLow, rrOne, victim;
  logic               regKnown, anyFree, useRr;
  logic               chkHit, chkConf, chkExc, isAdv, bad;

  always_comb begin
    freeVec  = ~validVec;
    freeLow  = freeVec & (~freeVec + ONE);
    rrOne    = ONE << rrPtr;
    regKnown = |allocRegHit;
    anyFree  = |freeVec;
    if (regKnown)     victim = allocRegHit;
    else if (anyFree) victim = freeLow;
    else              victim = rrOne;
    useRr = allocValid && !regKnown && !anyFree;

    isAdv   = (chkKind == CHK_ADV);
    chkHit  = |chkRegHit;
    chkConf = |(chkRegHit & confVec);
    chkExc  = |(chkRegHit & excVec);
    bad     = !chkHit || chkConf;

    strobe.allocSel = allocValid ? victim : '0;
    strobe.clearSel = (chkValid && isAdv) ? chkRegHit : '0;
    strobe.markSel  = storeValid ? storeAddrHit : '0;
    strobe.allocExc = allocExc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrPtr    <= '0;
      chkResp  <= 1'b0;
      refetch  <= 1'b0;
      fixup    <= 1'b0;
      excRaise <= 1'b0;
    end else begin
      if (useRr) rrPtr <= rrPtr + 1'b1;
      chkResp  <= chkValid;
      refetch  <= chkValid && !isAdv && bad;
      fixup    <= chkValid && isAdv && bad;
      excRaise <= chkValid && chkExc;
    end
  end
endmodule

// File: rtl/loadAliasTable.sv
module loadAliasTable
  import latPkg::*;
#(
  parameter int unsigned REG_W    = 7,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned LINE_LSB = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  input  logic [REG_W-1:0]  allocReg,
  input  logic [ADDR_W-1:0] allocAddr,
  input  logic              allocExc,
  input  logic              storeValid,
  input  logic [ADDR_W-1:0] storeAddr,
  input  logic              chkValid,
  input  logic [REG_W-1:0]  chkReg,
  input  logic              chkKind,
  output logic              chkResp,
  output logic              refetch,
  output logic              fixup,
  output logic              excRaise
);
  strobeT             strobe;
  logic [ENTRIES-1:0] allocRegHit, chkRegHit, storeAddrHit;
  logic [ENTRIES-1:0] validVec, confVec, excVec;

  latCtrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .allocExc(allocExc),
    .storeValid(storeValid), .chkValid(chkValid), .chkKind(chkKind),
    .allocRegHit(allocRegHit), .chkRegHit(chkRegHit),
    .storeAddrHit(storeAddrHit), .validVec(validVec),
    .confVec(confVec), .excVec(excVec),
    .strobe(strobe), .chkResp(chkResp), .refetch(refetch),
    .fixup(fixup), .excRaise(excRaise)
  );

  latData #(.REG_W(REG_W), .ADDR_W(ADDR_W), .LINE_LSB(LINE_LSB)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .allocReg(allocReg), .allocAddr(allocAddr), .storeAddr(storeAddr),
    .chkReg(chkReg),
    .allocRegHit(allocRegHit), .chkRegHit(chkRegHit),
    .storeAddrHit(storeAddrHit), .validVec(validVec),
    .confVec(confVec), .excVec(excVec)
  );
endmodule

// File: rtl/loadAliasTableChk.sv
module loadAliasTableChk #(
  parameter int unsigned REG_W  = 7,
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              allocValid,
  input logic [REG_W-1:0]  allocReg,
  input logic              allocExc,
  input logic              chkValid,
  input logic [REG_W-1:0]  chkReg,
  input logic              chkKind,
  input logic              chkResp,
  input logic              refetch,
  input logic              fixup,
  input logic              excRaise
);
  AST_NO_DOUBLE_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !(refetch && fixup)); // R4

  AST_RESP_AFTER_CHECK: assert property (@(posedge clk) disable iff (!rstN)
    chkValid |=> chkResp); // R11

  AST_QUIET_WITHOUT_CHECK: assert property (@(posedge clk) disable iff (!rstN)
    !chkValid |=> !chkResp && !refetch && !fixup && !excRaise); // R11

  AST_FRESH_ENTRY_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    ($past(allocValid) && !$past(allocExc) && chkValid && chkReg == $past(allocReg))
    |=> !refetch && !fixup && !excRaise); // R9

  AST_ADV_REMOVES: assert property (@(posedge clk) disable iff (!rstN)
    ($past(chkValid) && $past(chkKind) && !$past(allocValid) && chkValid
     && chkReg == $past(chkReg)) |=> (refetch || fixup)); // R5
endmodule

bind loadAliasTable loadAliasTableChk #(.REG_W(REG_W), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocReg(allocReg),
  .allocExc(allocExc), .chkValid(chkValid), .chkReg(chkReg),
  .chkKind(chkKind), .chkResp(chkResp), .refetch(refetch),
  .fixup(fixup), .excRaise(excRaise)
);

// File: tb/test_loadAliasTable.sv
module test_loadAliasTable;
  localparam int REG_W = 7;
  localparam int ADDR_W = 32;
  localparam int NENT = 16;

  logic clk = 0, rstN = 0;
  logic aV = 0, aE = 0, sV = 0, cV = 0, cK = 0;
  logic [REG_W-1:0] aR = '0, cR = '0;
  logic [ADDR_W-1:0] aA = '0, sA = '0;
  logic chkResp, refetch, fixup, excRaise;

  int total = 0, bad = 0;

  // bench model
  bit mVld [NENT];
  bit mConf[NENT];
  bit mExc [NENT];
  int mReg [NENT];
  int mTag [NENT];
  int mPtr;

  always #2 clk = ~clk;

  loadAliasTable i_loadAliasTable (
    .clk(clk), .rstN(rstN), .allocValid(aV), .allocReg(aR), .allocAddr(aA),
    .allocExc(aE), .storeValid(sV), .storeAddr(sA), .chkValid(cV),
    .chkReg(cR), .chkKind(cK), .chkResp(chkResp), .refetch(refetch),
    .fixup(fixup), .excRaise(excRaise)
  );

  function automatic int findReg(int r);
    for (int i = 0; i < NENT; i++) if (mVld[i] && mReg[i] == r) return i;
    return -1;
  endfunction

  task automatic check(string req, logic act, logic exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic idle();
    aV = 0; sV = 0; cV = 0; aE = 0;
  endtask

  // one clock of stimulus; expected values come from the bench model
  task automatic tick(string req);
    int hit, vic, ff;
    bit eResp, eRef, eFix, eExc, badChk;
    bit preVld[NENT];
    @(negedge clk);
    hit = findReg(int'(cR));
    badChk = (hit < 0) || mConf[hit];
    eResp = cV;
    eRef = cV && !cK && badChk;
    eFix = cV && cK && badChk;
    eExc = cV && hit >= 0 && mExc[hit];
    for (int i = 0; i < NENT; i++) preVld[i] = mVld[i];
    vic = findReg(int'(aR));
    if (vic < 0) begin
      ff = -1;
      for (int i = NENT - 1; i >= 0; i--) if (!preVld[i]) ff = i;
      if (ff >= 0) vic = ff;
      else if (aV) begin vic = mPtr; mPtr = (mPtr + 1) % NENT; end
    end
    if (sV)
      for (int i = 0; i < NENT; i++)
        if (preVld[i] && mTag[i] == int'(sA >> 3)) mConf[i] = 1;
    if (cV && cK && hit >= 0) begin
      mVld[hit] = 0; mConf[hit] = 0; mExc[hit] = 0;
    end
    if (aV) begin
      mVld[vic] = 1; mConf[vic] = 0; mExc[vic] = aE;
      mReg[vic] = int'(aR); mTag[vic] = int'(aA >> 3);
    end
    @(posedge clk);
    #1;
    check(req, chkResp, eResp, "chkResp");
    check(req, refetch, eRef, "refetch");
    check(req, fixup, eFix, "fixup");
    check(req, excRaise, eExc, "excRaise");
  endtask

  task automatic doAlloc(int r, int a, bit e, string req);
    idle(); aV = 1; aR = REG_W'(r); aA = ADDR_W'(a); aE = e; tick(req);
  endtask
  task automatic doStore(int a, string req);
    idle(); sV = 1; sA = ADDR_W'(a); tick(req);
  endtask
  task automatic doChk(int r, bit k, string req);
    idle(); cV = 1; cR = REG_W'(r); cK = k; tick(req);
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < NENT; i++) begin
      mVld[i] = 0; mConf[i] = 0; mExc[i] = 0; mReg[i] = 0; mTag[i] = 0;
    end
    mPtr = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", chkResp, 0, "chkResp in reset");
    check("R1", refetch, 0, "refetch in reset");
    @(negedge clk); rstN = 1;

    // R1 / R6: checks on an empty table are misses
    doChk(5, 0, "R1");
    doChk(5, 1, "R6");
    // R2: allocation then clean load-checks, entry kept
    doAlloc(3, 'h1000, 0, "R2");
    doChk(3, 0, "R2");
    doChk(3, 0, "R2");
    // R3: other doubleword ignored, same doubleword marks
    doStore('h1010, "R3");
    doChk(3, 0, "R3");
    doStore('h1007, "R3");
    doChk(3, 0, "R4");
    // R8: reallocation clears conflict
    doAlloc(3, 'h2000, 0, "R8");
    doChk(3, 0, "R8");
    // R9: store and alloc same cycle to same address
    idle(); aV = 1; aR = 4; aA = 'h3000; sV = 1; sA = 'h3000; tick("R9");
    doChk(4, 0, "R9");
    doStore('h3004, "R5");
    doChk(4, 1, "R5");
    doChk(4, 1, "R5");
    // R5: clean advance-check removes the entry
    doAlloc(6, 'h4000, 0, "R5");
    doChk(6, 1, "R5");
    doChk(6, 0, "R5");
    // R7: deferred exception raised on either check kind
    doAlloc(7, 'h5000, 1, "R7");
    doChk(7, 0, "R7");
    doChk(7, 1, "R7");
    // R11: check sees pre-state although a store hits it in the same cycle
    doAlloc(8, 'h6000, 0, "R11");
    idle(); cV = 1; cR = 8; cK = 0; sV = 1; sA = 'h6000; tick("R11");
    doChk(8, 0, "R11");
    // R10: fill the table and force round-robin evictions
    for (int r = 40; r < 60; r++) doAlloc(r, 'h8000 + r * 8, 0, "R10");
    for (int r = 40; r < 60; r++) doChk(r, 0, "R10");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      idle();
      aV = ($urandom % 3) == 0;
      aR = REG_W'(20 + $urandom % 20);
      aA = ADDR_W'('h9000 + ($urandom % 6) * 8 + $urandom % 8);
      aE = ($urandom % 5) == 0;
      sV = ($urandom % 3) == 0;
      sA = ADDR_W'('h9000 + ($urandom % 6) * 8 + $urandom % 8);
      cV = ($urandom % 2) == 0;
      cR = REG_W'(20 + $urandom % 20);
      cK = $urandom % 2;
      tick("R10");
    end
    idle();
    tick("R11");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule